// File: doc/BRIEF.md
# Reconfigurable Interleaved Column Driver Core

This block is the digital core of a 96-column display column driver. It contains a 96-stage bidirectional shift register. A static mode input splits the register into three lanes of 32 stages or six lanes of 16 stages. The lanes are interleaved across the columns with a stride equal to the lane count, so lane k owns columns k, k+N, k+2N and so on, and every clock fills N adjacent columns at once from N parallel port pins.

The shift direction decides the port roles. One port side carries the incoming lane data and the other side shows the last stage of each lane, so several devices can be chained. A 96-bit hold latch takes a copy of the register on a falling edge of the active-low capture input. A per-column output stage then applies three global overrides in a fixed priority: float, then force-low, then force-high.

The mode input may only change while wipe is asserted. Wipe and capture are sampled on the rising clock edge. Column numbers below are 0-based, so column c is bit c of the register and of the outputs. Port pin k belongs to lane k.

Top module: `dcd_column_driver`

## Requirements
- R1: Synchronous active-high `rst` clears the shift register and the hold latch. After reset, with all overrides inactive, `col_q` is all 0 and `col_oe` is all 1.
- R2: With `three_lane`=1 and `dir_up`=1, every rising edge loads `lo_in[k]` into column k for k<3, and column c≥3 takes the old column c-3.
- R3: With `three_lane`=0 and `dir_up`=1, every rising edge loads `lo_in[k]` into column k for k<6, and column c≥6 takes the old column c-6.
- R4: With `dir_up`=0, port pin `hi_in[k]` enters column 96-N+k, and column c<96-N takes the old column c+N, where N is the lane count (3 or 6).
- R5: With `dir_up`=1, `hi_out[k]` shows column 96-N+k, `hi_oe` is set for the active lanes and `lo_oe` is 0. With `dir_up`=0, `lo_out[k]` shows column k, `lo_oe` is set for the active lanes and `hi_oe` is 0. An inactive output pin reads 0.
- R6: In three-lane mode, pins 3 to 5 of both ports are unused. Their inputs are ignored and their `oe` bits stay 0. Inputs on the output side are ignored in both modes.
- R7: While `wipe_n` is 0, each rising edge clears every shift stage to 0.
- R8: The hold latch loads the shift register on the first rising edge where `capture_n` is sampled 0 after it was sampled 1. It keeps its value in every other cycle, including while `capture_n` stays low and on its rise.
- R9: While `float_all`=1, every `col_oe` bit is 0 and `col_q` reads 0, whatever the other inputs are.
- R10: While `float_all`=0 and `force_lo_n`=0, every column drives 0 with `col_oe` set, whatever `force_hi_n` is.
- R11: While `float_all`=0, `force_lo_n`=1 and `force_hi_n`=0, every column drives 1 with `col_oe` set.
- R12: With all overrides inactive, `col_q` equals the hold latch and `col_oe` is all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| three_lane | input | 1 | 1: three 32-stage lanes, 0: six 16-stage lanes |
| dir_up | input | 1 | 1: shift toward higher columns, 0: toward lower columns |
| wipe_n | input | 1 | Active-low synchronous clear of the shift register |
| capture_n | input | 1 | Active-low latch capture, acts on its falling edge |
| force_lo_n | input | 1 | Active-low force-all-low override |
| force_hi_n | input | 1 | Active-low force-all-high override |
| float_all | input | 1 | Puts all column outputs in high impedance |
| lo_in | input | 6 | Low-column port data in (used when dir_up=1) |
| lo_out | output | 6 | Low-column port data out (valid when dir_up=0) |
| lo_oe | output | 6 | Low-column port pin drive enables |
| hi_in | input | 6 | High-column port data in (used when dir_up=0) |
| hi_out | output | 6 | High-column port data out (valid when dir_up=1) |
| hi_oe | output | 6 | High-column port pin drive enables |
| col_q | output | 96 | Column output values |
| col_oe | output | 96 | Column output drive enables (0 = high impedance) |

## Verification
The bench loads full frames in all four combinations of lane count and direction. It uses arithmetic patterns, so a wrong interleave stride or a reversed entry pin shows up as misplaced columns in the latched image. The unused pins in three-lane mode and the output-side inputs carry 1s during loading. Any leak of these into the register corrupts known columns, and a wrong enable mask shows on the `oe` outputs. The latch is driven on after capture while the register keeps shifting, and `capture_n` is then raised. A design that is level sensitive or that loads on the rising edge would show the shifted data. All eight override combinations are swept to catch a swapped priority between force-low and force-high, or float not dominating.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    localparam int COLS_DEF   = 96;
    localparam int LANES_WIDE = 6;
    localparam int LANES_SLIM = 3;

    typedef enum logic {
        SHIFT_DOWN = 1'b0,
        SHIFT_UP   = 1'b1
    } shift_dir_e;

    typedef struct packed {
        logic float_all;
        logic force_lo_n;
        logic force_hi_n;
    } ovr_ctrl_t;

    typedef struct packed {
        logic q;
        logic oe;
    } pin_drive_t;

    // Fixed priority: float, then force low, then force high, then data.
    function automatic pin_drive_t resolve_pin(ovr_ctrl_t c, logic data);
        pin_drive_t r;
        if (c.float_all) begin
            r.q  = 1'b0;
            r.oe = 1'b0;
        end else if (!c.force_lo_n) begin
            r.q  = 1'b0;
            r.oe = 1'b1;
        end else if (!c.force_hi_n) begin
            r.q  = 1'b1;
            r.oe = 1'b1;
        end else begin
            r.q  = data;
            r.oe = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/dcd_shift_array.sv
module dcd_shift_array
    import dcd_pkg::*;
#(
    parameter int NCOL   = COLS_DEF,
    parameter int NSLIM  = LANES_SLIM,
    parameter int NWIDE  = LANES_WIDE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             three_lane,
    input  logic             dir_up,
    input  logic             wipe_n,
    input  logic [NWIDE-1:0] lo_in,
    input  logic [NWIDE-1:0] hi_in,
    output logic [NWIDE-1:0] lo_out,
    output logic [NWIDE-1:0] lo_oe,
    output logic [NWIDE-1:0] hi_out,
    output logic [NWIDE-1:0] hi_oe,
    output logic [NCOL-1:0]  sr_q
);

    localparam logic [NWIDE-1:0] SLIM_MASK = NWIDE'((1 << NSLIM) - 1);

    shift_dir_e       dir;
    logic [NWIDE-1:0] lane_on;
    logic [NWIDE-1:0] lo_eff;
    logic [NWIDE-1:0] hi_eff;
    logic [NWIDE-1:0] hi_tap;
    logic [NCOL-1:0]  sr_nxt;

    assign dir     = shift_dir_e'(dir_up);
    assign lane_on = three_lane ? SLIM_MASK : '1;
    assign lo_eff  = lo_in & lane_on & {NWIDE{dir == SHIFT_UP}};
    assign hi_eff  = hi_in & lane_on & {NWIDE{dir == SHIFT_DOWN}};

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        logic up_s, up_w, dn_s, dn_w;
        if (c < NSLIM) begin : g_us
            assign up_s = lo_eff[c];
        end else begin : g_us
            assign up_s = sr_q[c-NSLIM];
        end
        if (c < NWIDE) begin : g_uw
            assign up_w = lo_eff[c];
        end else begin : g_uw
            assign up_w = sr_q[c-NWIDE];
        end
        if (c >= NCOL - NSLIM) begin : g_ds
            assign dn_s = hi_eff[c-(NCOL-NSLIM)];
        end else begin : g_ds
            assign dn_s = sr_q[c+NSLIM];
        end
        if (c >= NCOL - NWIDE) begin : g_dw
            assign dn_w = hi_eff[c-(NCOL-NWIDE)];
        end else begin : g_dw
            assign dn_w = sr_q[c+NWIDE];
        end
        assign sr_nxt[c] = (dir == SHIFT_UP) ? (three_lane ? up_s : up_w)
                                             : (three_lane ? dn_s : dn_w);
    end

    for (genvar k = 0; k < NWIDE; k++) begin : g_tap
        if (k < NSLIM) begin : g_t
            assign hi_tap[k] = three_lane ? sr_q[NCOL-NSLIM+k] : sr_q[NCOL-NWIDE+k];
        end else begin : g_t
            assign hi_tap[k] = three_lane ? 1'b0 : sr_q[NCOL-NWIDE+k];
        end
    end

    assign hi_oe  = (dir == SHIFT_UP)   ? lane_on : '0;
    assign lo_oe  = (dir == SHIFT_DOWN) ? lane_on : '0;
    assign hi_out = hi_tap & hi_oe;
    assign lo_out = sr_q[NWIDE-1:0] & lo_oe;

    always_ff @(posedge clk) begin
        if (rst || !wipe_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_nxt;
        end
    end

    a_r7_wipe_clears: assert property (@(posedge clk) disable iff (rst)
        !wipe_n |=> (sr_q == '0));

    a_r2_slim_up_stride: assert property (@(posedge clk) disable iff (rst)
        (wipe_n && dir_up && three_lane)
        |=> (sr_q[NCOL-1:NSLIM] == $past(sr_q[NCOL-NSLIM-1:0])));

    a_r3_wide_up_stride: assert property (@(posedge clk) disable iff (rst)
        (wipe_n && dir_up && !three_lane)
        |=> (sr_q[NCOL-1:NWIDE] == $past(sr_q[NCOL-NWIDE-1:0])));

    a_r4_slim_down_stride: assert property (@(posedge clk) disable iff (rst)
        (wipe_n && !dir_up && three_lane)
        |=> (sr_q[NCOL-NSLIM-1:0] == $past(sr_q[NCOL-1:NSLIM])));

    a_r4_slim_down_entry: assert property (@(posedge clk) disable iff (rst)
        (wipe_n && !dir_up && three_lane)
        |=> (sr_q[NCOL-1:NCOL-NSLIM] == $past(hi_in[NSLIM-1:0])));

    a_r6_unused_quiet: assert property (@(posedge clk) disable iff (rst)
        three_lane |-> ((lo_oe[NWIDE-1:NSLIM] == '0) && (hi_oe[NWIDE-1:NSLIM] == '0)));

endmodule

// File: rtl/dcd_hold_latch.sv
module dcd_hold_latch #(
    parameter int NCOL = dcd_pkg::COLS_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            capture_n,
    input  logic [NCOL-1:0] sr_q,
    output logic [NCOL-1:0] hold_q
);

    logic cap_prev;
    logic cap_fall;

    assign cap_fall = cap_prev && !capture_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_prev <= 1'b1;
            hold_q   <= '0;
        end else begin
            cap_prev <= capture_n;
            if (cap_fall) begin
                hold_q <= sr_q;
            end
        end
    end

    a_r8_loads_on_fall: assert property (@(posedge clk) disable iff (rst)
        cap_fall |=> (hold_q == $past(sr_q)));

    a_r8_holds_otherwise: assert property (@(posedge clk) disable iff (rst)
        !cap_fall |=> $stable(hold_q));

endmodule

// File: rtl/dcd_col_stage.sv
module dcd_col_stage
    import dcd_pkg::*;
#(
    parameter int NCOL = COLS_DEF
) (
    input  ovr_ctrl_t       ctrl,
    input  logic [NCOL-1:0] hold_q,
    output logic [NCOL-1:0] col_q,
    output logic [NCOL-1:0] col_oe
);

    for (genvar c = 0; c < NCOL; c++) begin : g_pin
        pin_drive_t d;
        assign d         = resolve_pin(ctrl, hold_q[c]);
        assign col_q[c]  = d.q;
        assign col_oe[c] = d.oe;
    end

endmodule

// File: rtl/dcd_column_driver.sv
module dcd_column_driver
    import dcd_pkg::*;
#(
    parameter int NCOL  = COLS_DEF,
    parameter int NSLIM = LANES_SLIM,
    parameter int NWIDE = LANES_WIDE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             three_lane,
    input  logic             dir_up,
    input  logic             wipe_n,
    input  logic             capture_n,
    input  logic             force_lo_n,
    input  logic             force_hi_n,
    input  logic             float_all,
    input  logic [NWIDE-1:0] lo_in,
    output logic [NWIDE-1:0] lo_out,
    output logic [NWIDE-1:0] lo_oe,
    input  logic [NWIDE-1:0] hi_in,
    output logic [NWIDE-1:0] hi_out,
    output logic [NWIDE-1:0] hi_oe,
    output logic [NCOL-1:0]  col_q,
    output logic [NCOL-1:0]  col_oe
);

    logic [NCOL-1:0] sr_q;
    logic [NCOL-1:0] hold_q;
    ovr_ctrl_t       ctrl;

    assign ctrl = '{float_all: float_all, force_lo_n: force_lo_n, force_hi_n: force_hi_n};

    dcd_shift_array #(.NCOL(NCOL), .NSLIM(NSLIM), .NWIDE(NWIDE)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .three_lane (three_lane),
        .dir_up     (dir_up),
        .wipe_n     (wipe_n),
        .lo_in      (lo_in),
        .hi_in      (hi_in),
        .lo_out     (lo_out),
        .lo_oe      (lo_oe),
        .hi_out     (hi_out),
        .hi_oe      (hi_oe),
        .sr_q       (sr_q)
    );

    dcd_hold_latch #(.NCOL(NCOL)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .capture_n (capture_n),
        .sr_q      (sr_q),
        .hold_q    (hold_q)
    );

    dcd_col_stage #(.NCOL(NCOL)) u_cols (
        .ctrl   (ctrl),
        .hold_q (hold_q),
        .col_q  (col_q),
        .col_oe (col_oe)
    );

    a_r9_float_wins: assert property (@(posedge clk) disable iff (rst)
        float_all |-> (col_oe == '0));

    a_r10_low_beats_high: assert property (@(posedge clk) disable iff (rst)
        (!float_all && !force_lo_n) |-> ((col_q == '0) && (&col_oe)));

    a_r11_force_high: assert property (@(posedge clk) disable iff (rst)
        (!float_all && force_lo_n && !force_hi_n) |-> ((&col_q) && (&col_oe)));

    a_r12_follow_hold: assert property (@(posedge clk) disable iff (rst)
        (!float_all && force_lo_n && force_hi_n) |-> ((col_q == hold_q) && (&col_oe)));

    a_r5_one_side_drives: assert property (@(posedge clk) disable iff (rst)
        ((lo_oe & hi_oe) == '0));

endmodule

// File: tb/tb_dcd_column_driver.sv
module tb_dcd_column_driver;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 96;

    logic clk = 1'b0;
    logic rst, three_lane, dir_up, wipe_n, capture_n;
    logic force_lo_n, force_hi_n, float_all;
    logic [5:0] lo_in, hi_in, lo_out, lo_oe, hi_out, hi_oe;
    logic [NC-1:0] col_q, col_oe;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcd_column_driver dut (
        .clk(clk), .rst(rst), .three_lane(three_lane), .dir_up(dir_up),
        .wipe_n(wipe_n), .capture_n(capture_n), .force_lo_n(force_lo_n),
        .force_hi_n(force_hi_n), .float_all(float_all),
        .lo_in(lo_in), .lo_out(lo_out), .lo_oe(lo_oe),
        .hi_in(hi_in), .hi_out(hi_out), .hi_oe(hi_oe),
        .col_q(col_q), .col_oe(col_oe)
    );

    task automatic chk(string req, logic [NC-1:0] act, logic [NC-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit pat(int t, int k, int seed);
        return ((t * 5 + k * 3 + seed * 11) % 7) < 3;
    endfunction

    // Column n*j+k holds the bit sent on pin k at clock t.
    function automatic logic [NC-1:0] frame(int n, bit up, int seed);
        logic [NC-1:0] v;
        int len = NC / n;
        for (int c = 0; c < NC; c++) begin
            int j = c / n;
            int k = c % n;
            int t = up ? (len - 1 - j) : j;
            v[c] = pat(t, k, seed);
        end
        return v;
    endfunction

    function automatic logic [5:0] lanes_on(int n);
        return (n == 3) ? 6'b000111 : 6'b111111;
    endfunction

    task automatic wipe_cycle();
        wipe_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        wipe_n = 1'b1;
    endtask

    task automatic capture();
        capture_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Loads a full frame; unused and output-side pins carry 1s.
    task automatic load(int n, bit up, int seed, string req);
        logic [5:0] edge_exp;
        three_lane = (n == 3);
        dir_up = up;
        capture_n = 1'b1;
        wipe_cycle();
        for (int t = 0; t < NC / n; t++) begin
            for (int k = 0; k < 6; k++) begin
                bit v = (k < n) ? pat(t, k, seed) : 1'b1;
                lo_in[k] = up ? v : 1'b1;
                hi_in[k] = up ? 1'b1 : v;
            end
            @(posedge clk);
            @(negedge clk);
        end
        for (int k = 0; k < 6; k++) edge_exp[k] = (k < n) ? pat(0, k, seed) : 1'b0;
        if (up) begin
            chk("R5 hi_out", NC'(hi_out), NC'(edge_exp));
            chk("R5/R6 hi_oe", NC'(hi_oe), NC'(lanes_on(n)));
            chk("R5 lo_oe", NC'(lo_oe), '0);
        end else begin
            chk("R5 lo_out", NC'(lo_out), NC'(edge_exp));
            chk("R5/R6 lo_oe", NC'(lo_oe), NC'(lanes_on(n)));
            chk("R5 hi_oe", NC'(hi_oe), '0);
        end
        capture();
        capture_n = 1'b1;
        chk(req, col_q, frame(n, up, seed));
        chk("R12 col_oe", col_oe, '1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NC-1:0] img;
        rst = 1'b1; three_lane = 1'b1; dir_up = 1'b1; wipe_n = 1'b1;
        capture_n = 1'b1; force_lo_n = 1'b1; force_hi_n = 1'b1; float_all = 1'b0;
        lo_in = '0; hi_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 col_q", col_q, '0);
        chk("R1 col_oe", col_oe, '1);

        for (int s = 0; s < 2; s++) begin
            load(3, 1'b1, s, "R2 three-lane up frame, R6 unused pins ignored");
            load(6, 1'b1, s, "R3 six-lane up frame");
            load(3, 1'b0, s, "R4 three-lane down frame, R6 unused pins ignored");
            load(6, 1'b0, s, "R4 six-lane down frame");
        end

        // R8: keep shifting junk with capture_n held low, then raise it.
        load(6, 1'b1, 5, "R3 six-lane up frame seed5");
        img = frame(6, 1'b1, 5);
        capture();
        chk("R8 capture", col_q, img);
        for (int t = 0; t < 5; t++) begin
            lo_in = 6'(t * 13 + 7);
            @(posedge clk);
            @(negedge clk);
        end
        chk("R8 hold while low", col_q, img);
        capture_n = 1'b1;
        repeat (3) begin
            lo_in = ~lo_in;
            @(posedge clk);
            @(negedge clk);
        end
        chk("R8 no load on rise", col_q, img);

        // R7: wipe then capture an all-zero register.
        wipe_cycle();
        lo_in = '0;
        capture();
        capture_n = 1'b1;
        chk("R7 wipe clears", col_q, '0);

        load(3, 1'b1, 3, "R2 three-lane up frame seed3");
        img = frame(3, 1'b1, 3);
        for (int m = 0; m < 8; m++) begin
            logic [NC-1:0] eq, eoe;
            float_all  = m[2];
            force_lo_n = m[1];
            force_hi_n = m[0];
            #1;
            if (m[2]) begin
                eq = '0; eoe = '0;
            end else if (!m[1]) begin
                eq = '0; eoe = '1;
            end else if (!m[0]) begin
                eq = '1; eoe = '1;
            end else begin
                eq = img; eoe = '1;
            end
            chk("R9/R10/R11/R12 col_q", col_q, eq);
            chk("R9/R10/R11/R12 col_oe", col_oe, eoe);
        end
        float_all = 1'b0; force_lo_n = 1'b1; force_hi_n = 1'b1;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule